// File: doc/BRIEF.md
# Nibble-Written Bank Mapper

This block is the address-mapping controller of a cartridge attached to an 8-bit CPU with a 16-bit address bus. It watches CPU writes in the upper half of the address space and turns them into bank numbers. It then uses those bank numbers to translate CPU program addresses and video-side character addresses into addresses in banked ROM. Each bank number is eight bits wide and is loaded four bits at a time. Two writes, one for each half, build a complete number.

The CPU address space splits into four 8 KB program windows. The last window always shows the final ROM bank. The character space splits into eight 1 KB windows. The block also gates access to an 8 KB program RAM, which can be off, read-only or read-write. It drives a two-bit nametable mirroring code to the video side.

All outputs are registered and follow their inputs by one clock. The ROM and RAM arrays sit outside the block.

Top module: `nibble_bank_mapper`

## Requirements
- R1: A register write happens only on a clock edge where `cpu_we` is 1 and `cpu_addr[15]` is 1. Decoding looks only at `cpu_addr[15:12]` and `cpu_addr[1:0]`, so 0x9FF1 acts exactly as 0x9001. A write with `cpu_we` low, or a write below 0x8000, changes no bank number.
- R2: When `cpu_addr[0]` is 0, the write replaces bits 3:0 of the selected bank number. When it is 1, the write replaces bits 7:4. The other half is kept. Only `cpu_wdata[3:0]` is used.
- R3: The program window is selected by `cpu_addr[14:13]`. Windows 0, 1 and 2 take their banks from the register pairs at 0x8000/0x8001, 0x8002/0x8003 and 0x9000/0x9001. `prg_rom_addr` equals {bank, `cpu_addr[12:0]`}, one clock after the address is presented.
- R4: Addresses 0xE000 to 0xFFFF always map to bank PRG_BANKS-1, whatever has been written.
- R5: The character window is selected by `chr_addr_in[12:10]`. Windows 0 to 7 take their banks, in order, from the pairs 0xA000/1, 0xA002/3, 0xB000/1, 0xB002/3, 0xC000/1, 0xC002/3, 0xD000/1 and 0xD002/3. `chr_rom_addr` equals {bank, `chr_addr_in[9:0]`}, one clock later.
- R6: A stored bank number is reduced modulo PRG_BANKS (program) or CHR_BANKS (character) before it is used.
- R7: A write to 0x9002 sets the RAM mode from `cpu_wdata[1:0]`:
  - bit 0 clear gives no access;
  - bit 0 set with bit 1 clear gives read-only;
  - both bits set gives read-write.
- R8: For a CPU address in 0x6000 to 0x7FFF, `prg_ram_rd_en` is 1 when the mode is read-only or read-write. `prg_ram_wr_en` is 1 only when `cpu_we` is 1 and the mode is read-write. Both are 0 outside that range. `prg_ram_addr` equals `cpu_addr[12:0]`. All three follow the inputs by one clock.
- R9: A write to 0xF002 sets `mirror_mode` to `cpu_wdata[1:0]`: 0 horizontal, 1 vertical, 2 single-screen A, 3 single-screen B. The new value is visible after that clock edge.
- R10: Writes to 0xF003, 0xF000, 0xF001 and 0xE000 to 0xE003 change no bank, mode or mirroring state.
- R11: Synchronous reset has these effects:
  - it clears every bank number to 0;
  - it sets the RAM mode to no access;
  - it sets `mirror_mode` to MIRROR_RESET (default 1);
  - window 3 stays on the last bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| chr_addr_in | input | 13 | Video-side character address |
| prg_rom_addr | output | PRG_AW | Translated program ROM address |
| chr_rom_addr | output | CHR_AW | Translated character ROM address |
| prg_ram_addr | output | 13 | Program RAM address |
| prg_ram_rd_en | output | 1 | Program RAM read allowed |
| prg_ram_wr_en | output | 1 | Program RAM write strobe |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The bench builds bank numbers through pairs of half writes. Upper data bits are set so that a design that merged the full byte, or swapped the halves, would show the wrong bank. It uses ROM sizes that are not powers of two, so a design that masked bits instead of reducing modulo would produce out-of-range banks. It also writes through aliased addresses (0x9FF1) and through neighbours of live registers (0x9003, 0xF003, 0xE000). A decoder that compared too few or too many address bits would then corrupt state. The RAM gate is stepped through all three modes, including a mode value with only bit 1 set. A reset in the middle of a run must return every window and the mirroring code to the reset values.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  localparam int BANK_W     = 8;
  localparam int PRG_SLOTS  = 3;
  localparam int CHR_SLOTS  = 8;
  localparam int PRG_WIN_W  = 13;
  localparam int CHR_WIN_W  = 10;

  typedef enum logic [1:0] {
    MIR_HORIZ = 2'd0,
    MIR_VERT  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    RAM_OFF = 2'd0,
    RAM_RO  = 2'd1,
    RAM_RW  = 2'd2
  } ram_mode_e;
endpackage

// File: rtl/nbm_write_decode.sv
module nbm_write_decode
  import nbm_pkg::*;
(
  input  logic                 cpu_we,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_wdata,
  output logic [PRG_SLOTS-1:0] prg_sel,
  output logic [CHR_SLOTS-1:0] chr_sel,
  output logic                 ram_ctl_wr,
  output logic                 mir_wr,
  output logic                 nib_hi,
  output logic [3:0]           nib
);
  logic [3:0] top_n;
  logic [1:0] low_b;
  logic [3:0] grp;
  logic       active;
  logic       unused_bits;

  assign top_n       = cpu_addr[15:12];
  assign low_b       = cpu_addr[1:0];
  assign grp         = top_n - 4'hA;
  assign active      = cpu_we & cpu_addr[15];
  assign nib_hi      = low_b[0];
  assign nib         = cpu_wdata[3:0];
  assign unused_bits = ^{cpu_addr[11:2], cpu_wdata[7:4]};

  always_comb begin
    prg_sel    = '0;
    chr_sel    = '0;
    ram_ctl_wr = 1'b0;
    mir_wr     = 1'b0;
    if (active) begin
      case (top_n)
        4'h8: prg_sel[{1'b0, low_b[1]}] = 1'b1;
        4'h9: begin
          if (!low_b[1])       prg_sel[2] = 1'b1;
          else if (!low_b[0])  ram_ctl_wr = 1'b1;
        end
        4'hA, 4'hB, 4'hC, 4'hD: chr_sel[{grp[1:0], low_b[1]}] = 1'b1;
        4'hF: mir_wr = (low_b == 2'b10);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nbm_bank_regs.sv
module nbm_bank_regs
  import nbm_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SLOTS-1:0]             sel,
  input  logic                         nib_hi,
  input  logic [3:0]                   nib,
  output logic [SLOTS-1:0][BANK_W-1:0] bank
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [BANK_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= '0;
      else if (sel[i]) begin
        if (nib_hi) r[7:4] <= nib;
        else        r[3:0] <= nib;
      end
    end
    assign bank[i] = r;
  end
endmodule

// File: rtl/nbm_translate.sv
module nbm_translate
  import nbm_pkg::*;
#(
  parameter int PRG_BANKS = 12,
  parameter int CHR_BANKS = 40,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int CHR_BW = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRG_BW + PRG_WIN_W,
  localparam int CHR_AW = CHR_BW + CHR_WIN_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [15:0]                      cpu_addr,
  input  logic                             cpu_we,
  input  logic [12:0]                      chr_addr_in,
  input  logic [PRG_SLOTS-1:0][BANK_W-1:0] prg_bank,
  input  logic [CHR_SLOTS-1:0][BANK_W-1:0] chr_bank,
  input  ram_mode_e                        ram_mode,
  output logic [PRG_AW-1:0]                prg_rom_addr,
  output logic [CHR_AW-1:0]                chr_rom_addr,
  output logic [12:0]                      prg_ram_addr,
  output logic                             prg_ram_rd_en,
  output logic                             prg_ram_wr_en
);
  localparam logic [BANK_W-1:0] PRG_N = BANK_W'(PRG_BANKS);
  localparam logic [BANK_W-1:0] CHR_N = BANK_W'(CHR_BANKS);
  localparam logic [PRG_BW-1:0] PRG_LAST = PRG_BW'(PRG_BANKS - 1);

  logic [3:0][PRG_BW-1:0]           prg_win;
  logic [CHR_SLOTS-1:0][CHR_BW-1:0] chr_win;
  logic                             ram_hit;

  for (genvar p = 0; p < PRG_SLOTS; p++) begin : g_prg
    logic [BANK_W-1:0] red;
    assign red        = prg_bank[p] % PRG_N;
    assign prg_win[p] = red[PRG_BW-1:0];
  end
  assign prg_win[3] = PRG_LAST;

  for (genvar c = 0; c < CHR_SLOTS; c++) begin : g_chr
    logic [BANK_W-1:0] red;
    assign red        = chr_bank[c] % CHR_N;
    assign chr_win[c] = red[CHR_BW-1:0];
  end

  assign ram_hit = (cpu_addr[15:13] == 3'b011);

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_rom_addr  <= '0;
      chr_rom_addr  <= '0;
      prg_ram_addr  <= '0;
      prg_ram_rd_en <= 1'b0;
      prg_ram_wr_en <= 1'b0;
    end else begin
      prg_rom_addr  <= {prg_win[cpu_addr[14:13]], cpu_addr[12:0]};
      chr_rom_addr  <= {chr_win[chr_addr_in[12:10]], chr_addr_in[9:0]};
      prg_ram_addr  <= cpu_addr[12:0];
      prg_ram_rd_en <= ram_hit && (ram_mode != RAM_OFF);
      prg_ram_wr_en <= ram_hit && cpu_we && (ram_mode == RAM_RW);
    end
  end
endmodule

// File: rtl/nibble_bank_mapper.sv
module nibble_bank_mapper
  import nbm_pkg::*;
#(
  parameter int PRG_BANKS = 12,
  parameter int CHR_BANKS = 40,
  parameter logic [1:0] MIRROR_RESET = 2'd1,
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13,
  localparam int CHR_AW = $clog2(CHR_BANKS) + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic [12:0]       chr_addr_in,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic [CHR_AW-1:0] chr_rom_addr,
  output logic [12:0]       prg_ram_addr,
  output logic              prg_ram_rd_en,
  output logic              prg_ram_wr_en,
  output logic [1:0]        mirror_mode
);
  logic [PRG_SLOTS-1:0]             prg_sel;
  logic [CHR_SLOTS-1:0]             chr_sel;
  logic                             ram_ctl_wr, mir_wr, nib_hi;
  logic [3:0]                       nib;
  logic [PRG_SLOTS-1:0][BANK_W-1:0] prg_bank;
  logic [CHR_SLOTS-1:0][BANK_W-1:0] chr_bank;
  ram_mode_e                        ram_mode;

  nbm_write_decode u_dec (
    .cpu_we, .cpu_addr, .cpu_wdata,
    .prg_sel, .chr_sel, .ram_ctl_wr, .mir_wr, .nib_hi, .nib
  );

  nbm_bank_regs #(.SLOTS(PRG_SLOTS)) u_prg_regs (
    .clk, .rst, .sel(prg_sel), .nib_hi, .nib, .bank(prg_bank)
  );

  nbm_bank_regs #(.SLOTS(CHR_SLOTS)) u_chr_regs (
    .clk, .rst, .sel(chr_sel), .nib_hi, .nib, .bank(chr_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_mode    <= RAM_OFF;
      mirror_mode <= MIRROR_RESET;
    end else begin
      if (ram_ctl_wr)
        ram_mode <= !cpu_wdata[0] ? RAM_OFF : (cpu_wdata[1] ? RAM_RW : RAM_RO);
      if (mir_wr)
        mirror_mode <= cpu_wdata[1:0];
    end
  end

  nbm_translate #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_xlat (
    .clk, .rst, .cpu_addr, .cpu_we, .chr_addr_in,
    .prg_bank, .chr_bank, .ram_mode,
    .prg_rom_addr, .chr_rom_addr, .prg_ram_addr, .prg_ram_rd_en, .prg_ram_wr_en
  );
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
  parameter int PRG_BANKS = 12,
  parameter int CHR_BANKS = 40,
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13,
  localparam int CHR_AW = $clog2(CHR_BANKS) + 10
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_we,
  input logic [12:0]       chr_addr_in,
  input logic [PRG_AW-1:0] prg_rom_addr,
  input logic [CHR_AW-1:0] chr_rom_addr,
  input logic              prg_ram_rd_en,
  input logic              prg_ram_wr_en,
  input logic [1:0]        mirror_mode
);
  logic unused_bits;
  assign unused_bits = ^chr_addr_in[12:10];

  p_prg_offset_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prg_rom_addr[12:0] == $past(cpu_addr[12:0]));

  p_last_window_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b111) |=> (int'(prg_rom_addr[PRG_AW-1:13]) == PRG_BANKS - 1));

  p_chr_offset_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chr_rom_addr[9:0] == $past(chr_addr_in[9:0]));

  p_bank_range_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(prg_rom_addr[PRG_AW-1:13]) < PRG_BANKS) && (int'(chr_rom_addr[CHR_AW-1:10]) < CHR_BANKS));

  p_wr_needs_window_r8: assert property (@(posedge clk) disable iff (rst)
    prg_ram_wr_en |-> ($past(cpu_we) && $past(cpu_addr[15:13]) == 3'b011));

  p_wr_implies_rd_r8: assert property (@(posedge clk) disable iff (rst)
    prg_ram_wr_en |-> prg_ram_rd_en);

  p_mirror_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(cpu_we && cpu_addr[15:12] == 4'hF && cpu_addr[1:0] == 2'b10) |=> $stable(mirror_mode));
endmodule

bind nibble_bank_mapper nbm_checker #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .chr_addr_in(chr_addr_in),
  .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
  .prg_ram_rd_en(prg_ram_rd_en), .prg_ram_wr_en(prg_ram_wr_en), .mirror_mode(mirror_mode)
);

// File: tb/nibble_bank_mapper_tb_top.sv
module nibble_bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANKS = 12;
  localparam int CHR_BANKS = 40;
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
  localparam int CHR_AW = $clog2(CHR_BANKS) + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [12:0] chr_addr_in = '0;
  logic [PRG_AW-1:0] prg_rom_addr;
  logic [CHR_AW-1:0] chr_rom_addr;
  logic [12:0] prg_ram_addr;
  logic prg_ram_rd_en, prg_ram_wr_en;
  logic [1:0] mirror_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .MIRROR_RESET(2'd1)) dut_i (
    .clk, .rst, .cpu_addr, .cpu_wdata, .cpu_we, .chr_addr_in,
    .prg_rom_addr, .chr_rom_addr, .prg_ram_addr, .prg_ram_rd_en, .prg_ram_wr_en, .mirror_mode
  );

  typedef struct packed {
    logic        is_chr;
    logic [15:0] waddr;
    logic [7:0]  wdata;
    logic [15:0] probe;
    logic [7:0]  exp_bank;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h8000, 8'h05, 16'h8123, 8'd5},
    '{1'b0, 16'h8001, 8'hF1, 16'h9FFF, 8'd9},
    '{1'b0, 16'h8003, 8'h02, 16'hA000, 8'd8},
    '{1'b0, 16'h8002, 8'h37, 16'hB456, 8'd3},
    '{1'b0, 16'h9000, 8'h0A, 16'hC001, 8'd10},
    '{1'b0, 16'h9FF1, 8'h01, 16'hDFFF, 8'd2},
    '{1'b0, 16'hE000, 8'h07, 16'hE000, 8'd11},
    '{1'b0, 16'h0000, 8'h03, 16'h8000, 8'd9},
    '{1'b1, 16'hA000, 8'h03, 16'h03FF, 8'd3},
    '{1'b1, 16'hA003, 8'h02, 16'h0400, 8'd32},
    '{1'b1, 16'hD002, 8'h09, 16'h1FFF, 8'd9},
    '{1'b1, 16'hD003, 8'h03, 16'h1C00, 8'd17},
    '{1'b1, 16'hB001, 8'h01, 16'h0800, 8'd16},
    '{1'b1, 16'hC002, 8'h04, 16'h1400, 8'd4},
    '{1'b1, 16'hF003, 8'hFF, 16'h1C00, 8'd17}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic probe_cpu(input logic [15:0] a);
    cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe_chr(input logic [12:0] a);
    chr_addr_in = a;
    @(negedge clk);
  endtask

  task automatic chk_prg(input string req, input logic [15:0] a, input int bank);
    probe_cpu(a);
    chk(req, 32'(prg_rom_addr[PRG_AW-1:13]), 32'(bank));
    chk(req, 32'(prg_rom_addr[12:0]), 32'(a[12:0]));
  endtask

  task automatic chk_chr(input string req, input logic [12:0] a, input int bank);
    probe_chr(a);
    chk(req, 32'(chr_rom_addr[CHR_AW-1:10]), 32'(bank));
    chk(req, 32'(chr_rom_addr[9:0]), 32'(a[9:0]));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 mirror", 32'(mirror_mode), 32'd1);
    chk_prg("R11 window0", 16'h8000, 0);
    chk_prg("R11 R4 last window", 16'hE000, 11);
    chk_chr("R11 chr window0", 13'h0000, 0);
    probe_cpu(16'h6000);
    chk("R11 ram rd", 32'(prg_ram_rd_en), 32'd0);

    // table: nibble writes then probes (R2 R3 R5 R6)
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].waddr, VECS[i].wdata);
      if (VECS[i].is_chr) chk_chr("R2 R5 R6 chr vector", VECS[i].probe[12:0], int'(VECS[i].exp_bank));
      else                chk_prg("R1 R2 R3 R6 prg vector", VECS[i].probe, int'(VECS[i].exp_bank));
    end

    // R1: strobe low at a bank register address
    cpu_wdata = 8'h0F;
    chk_prg("R1 we low", 16'h8000, 9);

    // R7/R8 program RAM gate
    probe_cpu(16'h6000);
    chk("R8 off rd", 32'(prg_ram_rd_en), 32'd0);
    do_write(16'h9002, 8'h01);
    probe_cpu(16'h6000);
    chk("R7 ro rd", 32'(prg_ram_rd_en), 32'd1);
    do_write(16'h6010, 8'hAA);
    chk("R7 ro wr", 32'(prg_ram_wr_en), 32'd0);
    chk("R8 ram addr", 32'(prg_ram_addr), 32'h0010);
    do_write(16'h9002, 8'h03);
    do_write(16'h7FFF, 8'h55);
    chk("R7 rw wr", 32'(prg_ram_wr_en), 32'd1);
    chk("R7 rw rd", 32'(prg_ram_rd_en), 32'd1);
    chk("R8 ram addr top", 32'(prg_ram_addr), 32'h1FFF);
    do_write(16'h5FFF, 8'h00);
    chk("R8 below window", 32'(prg_ram_wr_en), 32'd0);
    do_write(16'h9003, 8'h00);
    do_write(16'h6000, 8'h11);
    chk("R1 R7 9003 ignored", 32'(prg_ram_wr_en), 32'd1);
    do_write(16'h9002, 8'h02);
    probe_cpu(16'h6000);
    chk("R7 bit1 only off", 32'(prg_ram_rd_en), 32'd0);
    do_write(16'h6000, 8'h22);
    chk("R8 off wr", 32'(prg_ram_wr_en), 32'd0);

    // R9 mirroring
    do_write(16'hF002, 8'h02); chk("R9 one-a", 32'(mirror_mode), 32'd2);
    do_write(16'hF002, 8'hFF); chk("R9 one-b", 32'(mirror_mode), 32'd3);
    do_write(16'hF002, 8'h00); chk("R9 horiz", 32'(mirror_mode), 32'd0);
    do_write(16'hF002, 8'h05); chk("R9 vert", 32'(mirror_mode), 32'd1);

    // R10 dead addresses
    do_write(16'hF003, 8'h02);
    do_write(16'hF001, 8'h03);
    do_write(16'hF000, 8'h00);
    do_write(16'hE001, 8'h0F);
    chk("R10 mirror kept", 32'(mirror_mode), 32'd1);
    chk_prg("R10 prg kept", 16'h8000, 9);
    chk_chr("R10 chr kept", 13'h1C00, 17);

    // R4 / R6 full byte
    do_write(16'h9001, 8'h0F);
    do_write(16'h9000, 8'h0F);
    chk_prg("R6 255 mod 12", 16'hC000, 3);
    chk_prg("R4 fixed last", 16'hE123, 11);

    // R11 reset in mid-run
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11 mirror after reset", 32'(mirror_mode), 32'd1);
    chk_prg("R11 prg after reset", 16'h8000, 0);
    chk_chr("R11 chr after reset", 13'h1C00, 0);
    probe_cpu(16'h6000);
    chk("R11 ram after reset", 32'(prg_ram_rd_en), 32'd0);

    finish_run();
  end
endmodule